// File: doc/BRIEF.md
# Receive Telegram Header Processor

This block services received telegrams on a serial bus whose communication cycle begins when the master sync telegram ends. A word-addressed RAM holds a chain of five-word receive headers. Each header sets the accepted address, the buffering mode, the address and time checks, and the expected length. The header's last control word points to the next header. On each cycle-start pulse the engine goes back to the first header and matches incoming telegrams, in order, against successive headers. It stores the data words after the header, updates the header's valid and error flags, and counts faults in the header's error word. A header whose two marker bits are not both zero ends the chain.

The RAM reserves words 0 to 10 for other functions, so the chain starts at word 11 (parameter `FIRST_HDR`). Header layout, relative to the header base P:
- Word P+0 holds the control fields: bits 7:0 address, bit 8 external transfer, bit 9 double buffer, bit 10 valid, bit 11 address check, bit 12 time check, bit 13 receive error, bits 15:14 marker.
- P+1 holds the expected start time in microseconds.
- P+2 holds the data length in words.
- P+3 bits AW-1:0 hold the next header address.
- P+4 holds the error count.
- Buffer 0 starts at P+5, and buffer 1 starts TLEN words later.

A second RAM port lets the host read and write any word. Reads on this port are combinational.

The engine moves through these states:
- IDLE after reset.
- HD0 to HD3 fetch header words 0 to 3, one per cycle. HD0 goes to END on a marker word.
- WAIT waits for a start strobe.
- ADR takes the address word.
- DATA stores words until the end strobe.
- FLAG writes the final control word.
- CNT updates the error count and follows the next pointer back to HD0.
- END stays there until the next cycle start.

A cycle-start pulse sends any state to HD0 at the first header.

Top module: `rx_hdr_proc`

## Requirements
- R1: After reset the engine is idle: telegrams change no RAM word until a `cyc_start` pulse, which moves processing to the header at word 11.
- R2: A header whose word-0 bits 15:14 are not 00 ends the chain. Telegrams are then ignored, and no RAM word changes, until the next `cyc_start`.
- R3: With word-0 bit 11 set, a telegram whose first word's bits 7:0 differ from word-0 bits 7:0 writes no data, leaves bits 7:0 alone, and counts as an error.
- R4: With word-0 bit 11 clear, any address is accepted, and the received address is written into word-0 bits 7:0 at the end of reception.
- R5: With word-0 bit 12 set, the `us_now` value seen with `rx_sof` must lie within plus or minus 2 of word 1, or the reception counts as an error. With bit 12 clear, time is not checked.
- R6: Single buffer (bit 9 = 0, or bit 8 = 1): data word i goes to P+5+i. Bit 10 is cleared when the start is seen, and it is set at the end only if there is no error.
- R7: Double buffer (bit 9 = 1, bit 8 = 0): data goes to buffer 1 (P+5+TLEN) when bit 10 is 0, and to buffer 0 when it is 1. Bit 10 toggles on an error-free end and is otherwise unchanged.
- R8: At the end of each reception, word-0 bit 13 is written 1 if there was any error and 0 if there was none. Errors are the CRC strobe, a time miss, an address mismatch, an end seen before any address word, and a word count that differs from word 2.
- R9: On an error, word 4 is incremented, saturating at 0xFFFF. An error-free reception leaves it unchanged.
- R10: After a reception the next header is taken from word-3 bits AW-1:0.
- R11: `host_rdata` shows the word at `host_addr` in the same cycle. When a host write and an engine write hit the same word in the same cycle, the engine's value is stored.
- R12: With word-0 bit 8 set, no data words are written to RAM. Flags and the error count are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Pulse at end of the sync telegram; restarts the header chain |
| us_now | input | 16 | Microsecond timebase restarted at cycle start |
| rx_sof | input | 1 | Start of a received telegram |
| rx_vld | input | 1 | A received word is present on `rx_data` (first word is the address) |
| rx_data | input | 16 | Received word |
| rx_eof | input | 1 | End of telegram, never in the same cycle as `rx_vld` |
| rx_crc_bad | input | 1 | CRC failure, valid with `rx_eof` |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at `host_addr` |

## Verification
The host port and the engine can both write the same RAM word in one cycle. The bench provokes this by raising a host write to the first data word of a buffer on the same edge that presents the first data word. It then reads the word back and expects the received value rather than the host value. A second overlap happens inside one telegram: the start strobe clears the valid flag while the time sample is taken. The bench reads the control word in the middle of the telegram to see the flag clear, and it runs telegrams exactly at the window edge and one microsecond beyond it.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
    localparam int DW      = 16;
    localparam int B_DMA   = 8;
    localparam int B_DBUF  = 9;
    localparam int B_VAL   = 10;
    localparam int B_ACHK  = 11;
    localparam int B_TCHK  = 12;
    localparam int B_RERR  = 13;
    localparam int HDR_LEN = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HD0, ST_HD1, ST_HD2, ST_HD3,
        ST_WAIT, ST_ADR, ST_DATA, ST_FLAG, ST_CNT, ST_END
    } rxh_st_e;
endpackage

// File: rtl/rxh_ram.sv
module rxh_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_waddr,
    input  logic [DW-1:0] a_wdata,
    input  logic [AW-1:0] a_raddr,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          clash;

    // engine port wins a same-word collision (R11)
    assign clash = a_we && b_we && (a_waddr == b_addr);

    always_ff @(posedge clk) begin
        if (b_we && !clash) mem[b_addr]  <= b_wdata;
        if (a_we)           mem[a_waddr] <= a_wdata;
    end

    assign a_rdata = mem[a_raddr];
    assign b_rdata = mem[b_addr];
endmodule

// File: rtl/rxh_win_chk.sv
module rxh_win_chk #(
    parameter int TW  = 16,
    parameter int TOL = 2
) (
    input  logic [TW-1:0] now_t,
    input  logic [TW-1:0] tgt_t,
    output logic          in_win
);
    localparam logic [TW-1:0] TOL_V = TW'(TOL);

    logic [TW-1:0] d_late;
    logic [TW-1:0] d_early;

    assign d_late  = now_t - tgt_t;
    assign d_early = tgt_t - now_t;
    assign in_win  = (d_late <= TOL_V) || (d_early <= TOL_V);
endmodule

// File: rtl/rxh_engine.sv
module rxh_engine
    import rxh_pkg::*;
#(
    parameter int AW        = 8,
    parameter int FIRST_HDR = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          rx_sof,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_eof,
    input  logic          rx_crc_bad,
    input  logic          win_ok,
    output logic [DW-1:0] exp_time,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output rxh_st_e       st_o,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] FIRST = AW'(FIRST_HDR);
    localparam logic [AW-1:0] OFS1  = AW'(1);
    localparam logic [AW-1:0] OFS2  = AW'(2);
    localparam logic [AW-1:0] OFS3  = AW'(3);
    localparam logic [AW-1:0] OFS4  = AW'(4);
    localparam logic [AW-1:0] OFSD  = AW'(HDR_LEN);
    localparam logic [DW-1:0] SAT   = '1;

    rxh_st_e       st, nx;
    logic [AW-1:0] ptr, nxt;
    logic [DW-1:0] w0, tgt, tlen, idx;
    logic          t_ok, a_bad, err_r;
    logic [7:0]    cap;

    logic          single, dbuf_sel, new_val, data_we, end_err;
    logic [AW-1:0] boff;
    logic [DW-1:0] fin_w0;

    assign single   = !w0[B_DBUF] || w0[B_DMA];
    assign dbuf_sel = !single && !w0[B_VAL];
    assign boff     = dbuf_sel ? tlen[AW-1:0] : '0;
    assign new_val  = single ? !err_r : (w0[B_VAL] ^ !err_r);
    assign data_we  = rx_vld && !a_bad && !w0[B_DMA] && (idx < tlen);
    assign end_err  = rx_crc_bad || a_bad || (w0[B_TCHK] && !t_ok) || (idx != tlen);
    assign fin_w0   = {w0[15:14], err_r, w0[12:11], new_val, w0[9:8],
                       w0[B_ACHK] ? w0[7:0] : cap};

    assign exp_time = tgt;
    assign st_o     = st;
    assign ptr_o    = ptr;

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ptr   <= FIRST;
            nxt   <= '0;
            w0    <= '0;
            tgt   <= '0;
            tlen  <= '0;
            idx   <= '0;
            t_ok  <= 1'b0;
            a_bad <= 1'b0;
            err_r <= 1'b0;
            cap   <= '0;
        end else begin
            st <= nx;
            unique case (st)
                ST_HD0: w0   <= rd_data;
                ST_HD1: tgt  <= rd_data;
                ST_HD2: tlen <= rd_data;
                ST_HD3: nxt  <= rd_data[AW-1:0];
                ST_WAIT: if (rx_sof) begin
                    t_ok <= win_ok;
                    if (single) w0[B_VAL] <= 1'b0;
                end
                ST_ADR: begin
                    if (rx_vld) begin
                        a_bad <= w0[B_ACHK] && (rx_data[7:0] != w0[7:0]);
                        cap   <= rx_data[7:0];
                        idx   <= '0;
                    end else if (rx_eof) begin
                        err_r <= 1'b1;
                        cap   <= w0[7:0];
                    end
                end
                ST_DATA: begin
                    if (rx_vld) idx <= idx + 1'b1;
                    if (rx_eof) err_r <= end_err;
                end
                ST_CNT: ptr <= nxt;
                default: ;
            endcase
            if (cyc_start) ptr <= FIRST;
        end
    end

    // next state
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE: nx = ST_IDLE;
            ST_HD0:  nx = (rd_data[15:14] != 2'b00) ? ST_END : ST_HD1;
            ST_HD1:  nx = ST_HD2;
            ST_HD2:  nx = ST_HD3;
            ST_HD3:  nx = ST_WAIT;
            ST_WAIT: if (rx_sof) nx = ST_ADR;
            ST_ADR:  if (rx_vld) nx = ST_DATA; else if (rx_eof) nx = ST_FLAG;
            ST_DATA: if (rx_eof) nx = ST_FLAG;
            ST_FLAG: nx = ST_CNT;
            ST_CNT:  nx = ST_HD0;
            ST_END:  nx = ST_END;
            default: nx = ST_IDLE;
        endcase
        if (cyc_start) nx = ST_HD0;
    end

    // outputs: RAM read address and engine write port
    always_comb begin
        rd_addr = ptr;
        wr_en   = 1'b0;
        wr_addr = ptr;
        wr_data = w0;
        unique case (st)
            ST_HD1: rd_addr = ptr + OFS1;
            ST_HD2: rd_addr = ptr + OFS2;
            ST_HD3: rd_addr = ptr + OFS3;
            ST_CNT: begin
                rd_addr = ptr + OFS4;
                wr_addr = ptr + OFS4;
                wr_data = rd_data + 1'b1;
                wr_en   = err_r && (rd_data != SAT);
            end
            ST_WAIT: begin
                wr_en   = rx_sof && single;
                wr_data = w0 & ~(DW'(1) << B_VAL);
            end
            ST_DATA: begin
                wr_en   = data_we;
                wr_addr = ptr + OFSD + boff + idx[AW-1:0];
                wr_data = rx_data;
            end
            ST_FLAG: begin
                wr_en   = 1'b1;
                wr_data = fin_w0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_hdr_proc.sv
module rx_hdr_proc
    import rxh_pkg::*;
#(
    parameter int AW        = 8,
    parameter int FIRST_HDR = 11,
    parameter int TOL       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic [15:0]   us_now,
    input  logic          rx_sof,
    input  logic          rx_vld,
    input  logic [15:0]   rx_data,
    input  logic          rx_eof,
    input  logic          rx_crc_bad,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata
);
    logic          eng_we;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata;
    logic [AW-1:0] eng_raddr;
    logic [DW-1:0] eng_rdata;
    logic [DW-1:0] exp_time;
    logic          win_ok;
    rxh_st_e       eng_st;
    logic [AW-1:0] eng_ptr;

    rxh_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .a_we    (eng_we),
        .a_waddr (eng_addr),
        .a_wdata (eng_wdata),
        .a_raddr (eng_raddr),
        .a_rdata (eng_rdata),
        .b_we    (host_we),
        .b_addr  (host_addr),
        .b_wdata (host_wdata),
        .b_rdata (host_rdata)
    );

    rxh_win_chk #(.TW(DW), .TOL(TOL)) u_win (
        .now_t  (us_now),
        .tgt_t  (exp_time),
        .in_win (win_ok)
    );

    rxh_engine #(.AW(AW), .FIRST_HDR(FIRST_HDR)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .rx_sof     (rx_sof),
        .rx_vld     (rx_vld),
        .rx_data    (rx_data),
        .rx_eof     (rx_eof),
        .rx_crc_bad (rx_crc_bad),
        .win_ok     (win_ok),
        .exp_time   (exp_time),
        .rd_addr    (eng_raddr),
        .rd_data    (eng_rdata),
        .wr_en      (eng_we),
        .wr_addr    (eng_addr),
        .wr_data    (eng_wdata),
        .st_o       (eng_st),
        .ptr_o      (eng_ptr)
    );
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker
    import rxh_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_start,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [15:0]   host_rdata,
    input logic          eng_we,
    input logic [AW-1:0] eng_addr,
    input logic [15:0]   eng_wdata,
    input rxh_st_e       eng_st,
    input logic [AW-1:0] eng_ptr
);
    p_restart_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (eng_st == ST_HD0));

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_IDLE) |-> !eng_we);

    p_end_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_END && !cyc_start) |=> (eng_st == ST_END));

    p_end_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_END) |-> !eng_we);

    p_flag_to_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_FLAG && !cyc_start) |=> (eng_st == ST_CNT));

    p_flag_hits_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_FLAG) |-> (eng_we && eng_addr == eng_ptr));

    p_count_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_CNT && eng_we) |-> (eng_wdata != 16'h0000));

    p_engine_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && eng_we && host_addr == eng_addr) |=>
        (!$stable(host_addr) || host_rdata == $past(eng_wdata)));
endmodule

bind rx_hdr_proc rxh_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .eng_we     (eng_we),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .eng_st     (eng_st),
    .eng_ptr    (eng_ptr)
);

// File: tb/sim_rx_hdr_proc.sv
`timescale 1ns/1ps
module sim_rx_hdr_proc;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic [15:0]   us_now = '0;
    logic          rx_sof = 1'b0;
    logic          rx_vld = 1'b0;
    logic [15:0]   rx_data = '0;
    logic          rx_eof = 1'b0;
    logic          rx_crc_bad = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;

    always #2.5 clk = ~clk;

    rx_hdr_proc #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .us_now(us_now),
        .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_data(rx_data), .rx_eof(rx_eof),
        .rx_crc_bad(rx_crc_bad), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit chk_req = 1'b0;

    int          q_a[$];
    logic [15:0] q_v[$];
    string       q_t[$];

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic expect_w(input int a, input logic [15:0] v, input string tag);
        q_a.push_back(a);
        q_v.push_back(v);
        q_t.push_back(tag);
    endtask

    task automatic settle();
        chk_req = 1'b1;
        wait (chk_req == 1'b0);
    endtask

    // monitor: pops expected RAM words and compares through the host port
    initial begin
        forever begin
            wait (chk_req == 1'b1);
            while (q_a.size() > 0) begin
                int          a;
                logic [15:0] v;
                string       t;
                a = q_a.pop_front();
                v = q_v.pop_front();
                t = q_t.pop_front();
                @(negedge clk);
                host_addr = AW'(a);
                #1;
                check(t, host_rdata, v);
            end
            chk_req = 1'b0;
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = AW'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic cyc();
        @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // peek_a >= 0: read that control word mid-telegram and expect bit 10 clear
    task automatic send(input logic [15:0] t, input logic [7:0] adr, input int n,
                        input logic [15:0] base, input bit crc, input int clash_a,
                        input int peek_a);
        @(negedge clk);
        us_now = t;
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        rx_vld = 1'b1;
        rx_data = {8'h00, adr};
        if (peek_a >= 0) begin
            host_addr = AW'(peek_a);
            #1;
            check("R6 valid cleared at start", {15'd0, host_rdata[10]}, 16'd0);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_data = base + 16'(i);
            if (i == 0 && clash_a >= 0) begin
                host_we = 1'b1;
                host_addr = AW'(clash_a);
                host_wdata = 16'h1111;
            end else begin
                host_we = 1'b0;
            end
        end
        @(negedge clk);
        host_we = 1'b0;
        rx_vld = 1'b0;
        rx_eof = 1'b1;
        rx_crc_bad = crc;
        @(negedge clk);
        rx_eof = 1'b0;
        rx_crc_bad = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 11; a < 121; a++) wr(a, 16'hBEEF);
        wr(16, 16'hDEAD);
        // header 0 at 11: single, address check 0x21, time check at 100, len 3
        wr(11, 16'h3C21); wr(12, 16'd100); wr(13, 16'd3); wr(14, 16'd30); wr(15, 16'h0000);
        // header 1 at 30: double buffer, no address check, len 2
        wr(30, 16'h2200); wr(31, 16'd0); wr(32, 16'd2); wr(33, 16'd50); wr(34, 16'h0000);
        // header 2 at 50: single, address check 0x33, len 2, counter near full
        wr(50, 16'h0833); wr(51, 16'd0); wr(52, 16'd2); wr(53, 16'd70); wr(54, 16'hFFFE);
        // header 3 at 70: external transfer, len 2
        wr(70, 16'h0100); wr(71, 16'd0); wr(72, 16'd2); wr(73, 16'd90); wr(74, 16'h0000);
        // end marker at 90
        wr(90, 16'h8000);

        // reset state: idle engine ignores telegrams
        send(16'd100, 8'h21, 3, 16'hA000, 1'b0, -1, -1);
        expect_w(16, 16'hDEAD, "R1 idle no data write");
        expect_w(11, 16'h3C21, "R1 idle header untouched");
        settle();

        // cycle 1
        cyc();
        send(16'd101, 8'h21, 3, 16'hA000, 1'b0, -1, 11);
        expect_w(16, 16'hA000, "R6 single data 0");
        expect_w(18, 16'hA002, "R6 single data 2");
        expect_w(11, 16'h1C21, "R8 good clears error, sets valid");
        expect_w(15, 16'h0000, "R9 no count on good");
        settle();

        send(16'd7, 8'h5A, 2, 16'hB000, 1'b0, -1, -1);
        expect_w(37, 16'hB000, "R10 next header via pointer / R7 buffer 1");
        expect_w(38, 16'hB001, "R7 buffer 1 word 1");
        expect_w(35, 16'hBEEF, "R7 buffer 0 untouched");
        expect_w(30, 16'h065A, "R4 address captured, valid toggled");
        settle();

        send(16'd0, 8'h34, 2, 16'hC000, 1'b0, -1, -1);
        expect_w(55, 16'hBEEF, "R3 mismatch no data");
        expect_w(50, 16'h2833, "R3 mismatch error flag, address kept");
        expect_w(54, 16'hFFFF, "R9 count increments");
        settle();

        send(16'd0, 8'h44, 2, 16'hD000, 1'b0, -1, -1);
        expect_w(75, 16'hBEEF, "R12 no data stored");
        expect_w(76, 16'hBEEF, "R12 no data stored word 1");
        expect_w(70, 16'h0544, "R12 flags updated");
        settle();

        send(16'd0, 8'h21, 2, 16'hE000, 1'b0, -1, -1);
        expect_w(95, 16'hBEEF, "R2 after end no write");
        expect_w(90, 16'h8000, "R2 marker untouched");
        expect_w(16, 16'hA000, "R2 first header untouched");
        settle();

        // cycle 2
        cyc();
        send(16'd98, 8'h21, 3, 16'h5000, 1'b0, 16, -1);
        expect_w(16, 16'h5000, "R11 engine wins collision");
        expect_w(11, 16'h1C21, "R5 edge of window passes");
        settle();

        send(16'd0, 8'h6B, 2, 16'h6000, 1'b1, -1, -1);
        expect_w(35, 16'h6000, "R7 buffer 0 used when valid=1");
        expect_w(30, 16'h266B, "R7 error keeps valid, R8 error set");
        expect_w(34, 16'h0001, "R9 count on crc error");
        settle();

        send(16'd0, 8'h33, 2, 16'h7000, 1'b1, -1, -1);
        expect_w(54, 16'hFFFF, "R9 count saturates");
        expect_w(50, 16'h2833, "R8 crc error flag");
        settle();

        send(16'd0, 8'h45, 1, 16'h8000, 1'b0, -1, -1);
        expect_w(70, 16'h2145, "R8 length error");
        expect_w(74, 16'h0001, "R9 count on length error");
        settle();

        // cycle 3: one beyond the window
        cyc();
        send(16'd103, 8'h21, 3, 16'h9000, 1'b0, -1, -1);
        expect_w(11, 16'h3821, "R5 outside window is error");
        expect_w(15, 16'h0001, "R9 count on time miss");
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule